// File: doc/BRIEF.md
# Synchronous Byte FIFO with Overflow Drop Counter

A single-clock first-in first-out buffer holding ten bytes in flip-flops. A producer raises `wr_en` with a byte on `wr_data`. A consumer raises `rd_en` and receives the oldest stored byte on `rd_data` after the clock edge. The fill level is held in an up/down counter, and that counter alone drives the `full` and `empty` flags. The read and write positions wrap explicitly, because the depth is not a power of two.

A write request that finds the buffer full, with no read accepted on the same edge, is discarded. It is tallied in a 7-bit counter, `drop_count`, that stops at its maximum value. A read request that finds the buffer empty has no effect. A read and a write on the same edge both take place and leave the fill level unchanged. This also holds when the buffer is full, because the read frees the slot that the write then fills.

Top module: `sfifo_drop`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `empty`=1, `full`=0, `drop_count`=0 and `rd_data`=0.
- R2: Bytes leave on `rd_data` in exactly the order they were accepted, for every fill level from 0 to 10.
- R3: `empty` is 1 exactly when zero bytes are held, and `full` is 1 exactly when ten bytes are held. Both flags are registered and reflect the level after the latest clock edge.
- R4: A write request while `full`=1 with no accepted read stores nothing. The held bytes and their order are unchanged, and `drop_count` rises by one.
- R5: `drop_count` saturates at 127 and stays there under further dropped writes.
- R6: A read request while `empty`=1 is ignored. `rd_data` keeps its value, `empty` stays 1 unless a write is accepted on the same edge, and later traffic is unaffected.
- R7: A simultaneous read and write leaves the fill level unchanged. When the buffer is full, the write is accepted, `drop_count` does not change, and the written byte is delivered after the nine older bytes.
- R8: `rd_data` changes only on the clock edge of an accepted read and holds its value on every other cycle.
- R9: Ordering and flags stay correct over long mixed traffic in which both positions wrap from 9 to 0 many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Registered oldest byte, updated on an accepted read |
| full | output | 1 | Ten bytes held |
| empty | output | 1 | No bytes held |
| drop_count | output | 7 | Saturating count of discarded writes |

## Verification
Every fill level from 0 to 10 is set up from reset and then hit with each of the four combinations of read and write request, followed by a full drain. This separates a refused read at level 0, a dropped write at level 10, and the read-plus-write case at both extremes and in between. A long run of more than a hundred writes into a full buffer separates counting from saturation. A pseudo-random mixed stream of several hundred cycles wraps both positions many times and exposes wrap or ordering faults that short sweeps miss.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    parameter int unsigned FIFO_DEPTH = 10;
    parameter int unsigned WORD_W     = 8;
    parameter int unsigned DROP_W     = 7;

    localparam int unsigned PTR_W = $clog2(FIFO_DEPTH);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [DROP_W-1:0] drop_t;

    typedef struct packed {
        lvl_t level;
        logic full;
        logic empty;
    } lvl_state_t;
endpackage

// File: rtl/sfifo_ptr_wrap.sv
module sfifo_ptr_wrap
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output ptr_t ptr
);
    localparam ptr_t LAST = ptr_t'(FIFO_DEPTH - 1);

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q == LAST) ptr_d = '0;
            else               ptr_d = ptr_q + ptr_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/sfifo_level.sv
module sfifo_level
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic empty
);
    localparam lvl_t TOP = lvl_t'(FIFO_DEPTH);

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc, dec})
            2'b10:   st_d.level = st_q.level + lvl_t'(1);
            2'b01:   st_d.level = st_q.level - lvl_t'(1);
            default: st_d.level = st_q.level;
        endcase
        st_d.full  = (st_d.level == TOP);
        st_d.empty = (st_d.level == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{level: '0, full: 1'b0, empty: 1'b1};
        else        st_q <= st_d;
    end

    assign full  = st_q.full;
    assign empty = st_q.empty;
endmodule

// File: rtl/sfifo_sat_cnt.sv
module sfifo_sat_cnt
    import sfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    output drop_t count
);
    drop_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) cnt_d = cnt_q + drop_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ptr_t  waddr,
    input  word_t wdata,
    input  logic  re,
    input  ptr_t  raddr,
    output word_t rdata
);
    word_t mem_q [FIFO_DEPTH];
    word_t rd_d, rd_q;

    for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_word
        word_t word_d;
        always_comb begin
            word_d = mem_q[i];
            if (we && (waddr == ptr_t'(i))) word_d = wdata;
        end
        always_ff @(posedge clk) begin
            mem_q[i] <= word_d;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (re) rd_d = mem_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/sfifo_drop.sv
module sfifo_drop
    import sfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic [DROP_W-1:0] drop_count
);
    logic rd_take, wr_take, wr_lost;
    ptr_t wr_ptr, rd_ptr;

    // Read is granted whenever something is held; a write is granted when a
    // slot is free now or is being freed by the read on this same edge.
    always_comb begin
        rd_take = rd_en & ~empty;
        wr_take = wr_en & (~full | rd_take);
        wr_lost = wr_en & ~wr_take;
    end

    sfifo_ptr_wrap i_wr_ptr (.clk(clk), .rst_n(rst_n), .adv(wr_take), .ptr(wr_ptr));
    sfifo_ptr_wrap i_rd_ptr (.clk(clk), .rst_n(rst_n), .adv(rd_take), .ptr(rd_ptr));

    sfifo_level i_level (
        .clk(clk), .rst_n(rst_n), .inc(wr_take), .dec(rd_take),
        .full(full), .empty(empty)
    );

    sfifo_sat_cnt i_drop (.clk(clk), .rst_n(rst_n), .inc(wr_lost), .count(drop_count));

    sfifo_store i_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_take), .waddr(wr_ptr), .wdata(wr_data),
        .re(rd_take), .raddr(rd_ptr), .rdata(rd_data)
    );
endmodule

// File: rtl/sfifo_drop_chk.sv
module sfifo_drop_chk
    import sfifo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_data,
    input logic              full,
    input logic              empty,
    input logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] SAT = '1;

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R4
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && drop_count != SAT)
        |=> (drop_count == $past(drop_count) + 1'b1) && full);

    // R5
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == SAT) |=> (drop_count == SAT));

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> (empty && $stable(rd_data)));

    // R7
    full_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> (full && $stable(drop_count)));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind sfifo_drop sfifo_drop_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty), .drop_count(drop_count)
);

// File: tb/test_sfifo_drop.sv
`timescale 1ns/1ps
module test_sfifo_drop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       full, empty;
    logic [6:0] drop_count;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mq[$];
    logic [7:0] exp_rd = '0;
    int         exp_drop = 0;
    logic [7:0] dval = 8'h11;

    always #4 clk = ~clk;

    sfifo_drop i_sfifo_drop (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .drop_count(drop_count)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input string rd_tag);
        check(rd_tag, "rd_data", int'(rd_data), int'(exp_rd));
        check(tag, "full", int'(full), int'(mq.size() == 10));
        check(tag, "empty", int'(empty), int'(mq.size() == 0));
        check(tag, "drop_count", int'(drop_count), exp_drop);
    endtask

    // Called just after a falling edge; drives, advances one rising edge, checks at next falling edge.
    task automatic cyc(input logic w, input logic r, input string tag);
        logic rok, wok;
        wr_en = w; rd_en = r; wr_data = dval;
        rok = r && (mq.size() > 0);
        wok = w && ((mq.size() < 10) || rok);
        if (rok) exp_rd = mq.pop_front();
        if (wok) mq.push_back(dval);
        if (w && !wok && exp_drop < 127) exp_drop++;
        if (w) dval = dval + 8'd37;
        @(negedge clk);
        check_all(tag, rok ? tag : "R8");
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        mq.delete(); exp_rd = '0; exp_drop = 0;
        @(negedge clk);
        check_all("R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", "R1");
    endtask

    initial begin
        #(8 * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        do_reset();

        // Every level 0..10 times every request combination, then full drain.
        for (int lvl = 0; lvl <= 10; lvl++) begin
            for (int combo = 0; combo < 4; combo++) begin
                string tag;
                do_reset();
                for (int k = 0; k < lvl; k++) cyc(1'b1, 1'b0, "R3");
                if (combo == 3)                   tag = "R7";
                else if (combo == 1 && lvl == 0)  tag = "R6";
                else if (combo == 2 && lvl == 10) tag = "R4";
                else                              tag = "R2";
                cyc(combo[1], combo[0], tag);
                while (mq.size() > 0) cyc(1'b0, 1'b1, "R2");
                cyc(1'b0, 1'b1, "R6");
                cyc(1'b1, 1'b0, "R6");
                cyc(1'b0, 1'b1, "R6");
            end
        end

        // Saturation of the drop counter.
        do_reset();
        for (int k = 0; k < 10; k++) cyc(1'b1, 1'b0, "R3");
        for (int k = 0; k < 135; k++) cyc(1'b1, 1'b0, (k < 127) ? "R4" : "R5");
        check("R5", "drop_count final", int'(drop_count), 127);
        cyc(1'b1, 1'b1, "R7");
        while (mq.size() > 0) cyc(1'b0, 1'b1, "R7");

        // Long mixed traffic to wrap both positions repeatedly.
        do_reset();
        lfsr = 8'hA5;
        for (int k = 0; k < 800; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0] | (k[7] & lfsr[2]), lfsr[1] | (~k[7] & lfsr[3]), "R9");
        end
        while (mq.size() > 0) cyc(1'b0, 1'b1, "R9");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule